// File: doc/BRIEF.md
# Floating-Point Compare-to-Mask Unit

This unit compares two IEEE-754 operand bit patterns and produces a full-width mask: every bit set when the selected relation holds between the operands, every bit clear when it does not. It handles single and double precision. A 6-bit function field chooses one of several predicates and whether the compare is signaling. The unit also reports an illegal-operation flag, an invalid-operation cause and an accumulated invalid flag.

Operands are classified in hardware into zeros of either sign, denormals, normals, infinities, quiet NaNs and signaling NaNs. From that classification the unit builds one relation out of less, equal, greater and unordered. The function field then picks which of those relations count as true.

Each request is presented with a one-cycle valid strobe. One clock later the unit returns the registered mask and flags together with an output valid pulse. Single-precision operands sit in the low 32 bits of each operand input.

Top module: `fp_cmp_mask`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R2: A true predicate gives `out_mask` of all ones across the operand width; a false predicate gives all zeros. In single precision (`in_dbl`=0) bits [63:32] of `out_mask` are always zero.
- R3: With `in_func[4]`=0 and `in_func[5]`=0, the code `in_func[2:0]` selects the predicate as follows:
  - 0 is never true.
  - 1 is unordered.
  - 2 is equal.
  - 3 is unordered or equal.
  - 4 is less.
  - 5 is unordered or less.
  - 6 is less or equal.
  - 7 is less, equal or unordered.
- R4: With `in_func[4]`=1 and `in_func[5]`=0, three codes of `in_func[2:0]` are legal:
  - Code 1 is true for any ordered pair.
  - Code 2 is true for less, greater or unordered.
  - Code 3 is true for less or greater.
- R5: With `in_func[4]`=1, the codes 0, 4, 5, 6 and 7 set `out_illegal`. The result is then a zero mask and no invalid cause.
- R6: `in_func[5]`=1 sets `out_illegal` whatever the other bits are. The result is then a zero mask and no invalid cause.
- R7: Any NaN operand makes the relation unordered. Positive and negative zero compare equal. Infinities, normals and denormals are ordered by their numeric value.
- R8: A signaling compare (`in_func[3]`=1) with any NaN operand sets `out_inv_cause`.
- R9: A signaling-NaN operand sets `out_inv_cause` even when `in_func[3]`=0.
- R10: `out_inv_sticky` is set by every legal operation that raises invalid. It is cleared only by reset. Illegal operations do not set it.
- R11: While reset is asserted, all outputs are zero.
- R12: In single precision, bits [63:32] of `in_a` and `in_b` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_dbl | input | 1 | 1 for double precision, 0 for single |
| in_a | input | 64 | First operand bit pattern |
| in_b | input | 64 | Second operand bit pattern |
| in_func | input | 6 | Function field: [2:0] code, [3] signaling, [4] negated set, [5] illegal |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_mask | output | 64 | Mask result |
| out_illegal | output | 1 | Illegal function code |
| out_inv_cause | output | 1 | Invalid-operation cause for this result |
| out_inv_sticky | output | 1 | Accumulated invalid-operation flag |

## Verification
On every cycle the assertions check the following properties:
- The one-cycle latency of the valid pulse.
- That a mask is only ever zero or full for the precision that was requested.
- That an illegal result carries no mask and no invalid cause.
- That the function bit for illegal operations always reaches the illegal flag.
- That the accumulated invalid flag never drops outside reset.

The predicate tables, the ordering of signed zeros, denormals and infinities, and the invalid rules for quiet and signaling NaNs can only be shown by the bench. It sweeps every function code against every pair drawn from a set of operand classes, in both precisions. It compares each result against a rank-based model.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;

  localparam int RES_W  = 64;
  localparam int SGL_W  = 32;
  localparam int FUNC_W = 6;

  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;

  // function field bit positions
  localparam int FN_CODE_LSB = 0;
  localparam int FN_CODE_W   = 3;
  localparam int FN_SIG_BIT  = 3;
  localparam int FN_NEG_BIT  = 4;
  localparam int FN_BAD_BIT  = 5;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } rel_t;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fpclass_t;

endpackage

// File: rtl/fp_operand_class.sv
module fp_operand_class
  import fp_cmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fpclass_t             cls,
  output logic [EXP_W+MAN_W:0] key
);
  localparam int TOP = EXP_W + MAN_W;

  logic             sign;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic             exp_max;
  logic             man_nz;

  always_comb begin
    sign    = val[TOP];
    expo    = val[TOP-1:MAN_W];
    man     = val[MAN_W-1:0];
    exp_max = &expo;
    man_nz  = |man;

    cls.is_nan  = exp_max & man_nz;
    cls.is_snan = exp_max & man_nz & ~man[MAN_W-1];
    cls.is_zero = ~(|expo) & ~man_nz;

    // monotonic unsigned key: negatives inverted, positives lifted
    if (sign) key = ~val;
    else      key = {1'b1, val[TOP-1:0]};
  end

endmodule

// File: rtl/fp_order_rel.sv
module fp_order_rel
  import fp_cmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opa,
  input  logic [EXP_W+MAN_W:0] opb,
  output rel_t                 rel,
  output logic                 any_nan,
  output logic                 any_snan
);
  localparam int OW = EXP_W + MAN_W + 1;

  fpclass_t        cls_a, cls_b;
  logic [OW-1:0]   key_a, key_b;

  fp_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .val(opa), .cls(cls_a), .key(key_a)
  );
  fp_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .val(opb), .cls(cls_b), .key(key_b)
  );

  always_comb begin
    any_nan  = cls_a.is_nan  | cls_b.is_nan;
    any_snan = cls_a.is_snan | cls_b.is_snan;
    rel      = '0;
    if (any_nan) begin
      rel.un = 1'b1;
    end else if ((cls_a.is_zero & cls_b.is_zero) || (key_a == key_b)) begin
      rel.eq = 1'b1;
    end else if (key_a < key_b) begin
      rel.lt = 1'b1;
    end else begin
      rel.gt = 1'b1;
    end
  end

endmodule

// File: rtl/fp_pred_decode.sv
module fp_pred_decode
  import fp_cmp_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  rel_t              rel,
  input  logic              any_nan,
  input  logic              any_snan,
  output logic              hit,
  output logic              illegal,
  output logic              invalid
);
  logic [FN_CODE_W-1:0] code;
  logic                 sig_cmp;
  logic                 neg_set;
  logic                 bad_op;

  always_comb begin
    code    = func[FN_CODE_LSB +: FN_CODE_W];
    sig_cmp = func[FN_SIG_BIT];
    neg_set = func[FN_NEG_BIT];
    bad_op  = func[FN_BAD_BIT];

    hit     = 1'b0;
    illegal = 1'b0;

    if (bad_op) begin
      illegal = 1'b1;
    end else if (!neg_set) begin
      // code bits weight unordered, equal and less
      hit = (code[0] & rel.un) | (code[1] & rel.eq) | (code[2] & rel.lt);
    end else begin
      unique case (code)
        3'd1:    hit = rel.lt | rel.gt | rel.eq;
        3'd2:    hit = rel.lt | rel.gt | rel.un;
        3'd3:    hit = rel.lt | rel.gt;
        default: illegal = 1'b1;
      endcase
    end

    if (illegal) hit = 1'b0;
    invalid = ~illegal & (any_snan | (sig_cmp & any_nan));
  end

endmodule

// File: rtl/fp_cmp_mask.sv
module fp_cmp_mask
  import fp_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_dbl,
  input  logic [RES_W-1:0]  in_a,
  input  logic [RES_W-1:0]  in_b,
  input  logic [FUNC_W-1:0] in_func,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_mask,
  output logic              out_illegal,
  output logic              out_inv_cause,
  output logic              out_inv_sticky
);
  localparam int SP_W = SP_EXP_W + SP_MAN_W + 1;
  localparam int DP_W = DP_EXP_W + DP_MAN_W + 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rel_t rel_s, rel_d, rel_sel;
  logic nan_s, nan_d, snan_s, snan_d;
  logic nan_sel, snan_sel;

  fp_order_rel #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_rel_sp (
    .opa(in_a[SP_W-1:0]), .opb(in_b[SP_W-1:0]),
    .rel(rel_s), .any_nan(nan_s), .any_snan(snan_s)
  );

  fp_order_rel #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_rel_dp (
    .opa(in_a[DP_W-1:0]), .opb(in_b[DP_W-1:0]),
    .rel(rel_d), .any_nan(nan_d), .any_snan(snan_d)
  );

  always_comb begin
    rel_sel  = in_dbl ? rel_d  : rel_s;
    nan_sel  = in_dbl ? nan_d  : nan_s;
    snan_sel = in_dbl ? snan_d : snan_s;
  end

  logic hit, illegal, invalid;

  fp_pred_decode u_dec (
    .func(in_func), .rel(rel_sel), .any_nan(nan_sel), .any_snan(snan_sel),
    .hit(hit), .illegal(illegal), .invalid(invalid)
  );

  // next-state
  logic [RES_W-1:0] mask_d, mask_q;
  logic             ill_d, ill_q;
  logic             cause_d, cause_q;
  logic             sticky_d, sticky_q;
  logic             vld_q;
  logic             res_en;

  always_comb begin
    res_en  = in_valid;
    mask_d  = '0;
    if (hit) begin
      if (in_dbl) mask_d = '1;
      else        mask_d = {{(RES_W-SGL_W){1'b0}}, {SGL_W{1'b1}}};
    end
    ill_d    = illegal;
    cause_d  = invalid;
    sticky_d = sticky_q | (in_valid & invalid);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q    <= 1'b0;
      mask_q   <= '0;
      ill_q    <= 1'b0;
      cause_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      vld_q    <= in_valid;
      sticky_q <= sticky_d;
      if (res_en) begin
        mask_q  <= mask_d;
        ill_q   <= ill_d;
        cause_q <= cause_d;
      end
    end
  end

  assign out_valid      = vld_q;
  assign out_mask       = mask_q;
  assign out_illegal    = ill_q;
  assign out_inv_cause  = cause_q;
  assign out_inv_sticky = sticky_q;

endmodule

// File: rtl/fp_cmp_mask_chk.sv
module fp_cmp_mask_chk
  import fp_cmp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_dbl,
  input logic             fn_bad,
  input logic             out_valid,
  input logic [RES_W-1:0] out_mask,
  input logic             out_illegal,
  input logic             out_inv_cause,
  input logic             out_inv_sticky
);
  localparam logic [RES_W-1:0] LOW_ONES = {{(RES_W-SGL_W){1'b0}}, {SGL_W{1'b1}}};

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask == '0) ||
                  ($past(in_dbl) && out_mask == '1) ||
                  (!$past(in_dbl) && out_mask == LOW_ONES));

  // R5
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_mask == '0 && !out_inv_cause));

  // R6
  bad_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fn_bad) |=> out_illegal);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(out_inv_sticky));

  // R10
  sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv_cause) |-> out_inv_sticky);

endmodule

bind fp_cmp_mask fp_cmp_mask_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
  .fn_bad(in_func[5]), .out_valid(out_valid), .out_mask(out_mask),
  .out_illegal(out_illegal), .out_inv_cause(out_inv_cause),
  .out_inv_sticky(out_inv_sticky)
);

// File: tb/sim_fp_cmp_mask.sv
`timescale 1ns/1ps
module sim_fp_cmp_mask;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_dbl;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic [5:0]  in_func;
  logic        out_valid;
  logic [63:0] out_mask;
  logic        out_illegal;
  logic        out_inv_cause;
  logic        out_inv_sticky;

  int  errs   = 0;
  int  checks = 0;
  bit  done   = 0;
  logic exp_sticky;

  fp_cmp_mask u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
    .in_a(in_a), .in_b(in_b), .in_func(in_func),
    .out_valid(out_valid), .out_mask(out_mask), .out_illegal(out_illegal),
    .out_inv_cause(out_inv_cause), .out_inv_sticky(out_inv_sticky)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam int NV = 11;

  // operand classes ordered by value; indices 9 and 10 are NaNs
  function automatic logic [31:0] sval(int i);
    case (i)
      0: return 32'hFF80_0000;  // -inf
      1: return 32'hBF80_0000;  // -1.0
      2: return 32'h8000_0001;  // -denormal
      3: return 32'h8000_0000;  // -0
      4: return 32'h0000_0000;  // +0
      5: return 32'h0000_0001;  // +denormal
      6: return 32'h3F80_0000;  // 1.0
      7: return 32'h4000_0000;  // 2.0
      8: return 32'h7F80_0000;  // +inf
      9: return 32'h7FC0_0000;  // quiet NaN
      default: return 32'h7F80_0001; // signaling NaN
    endcase
  endfunction

  function automatic logic [63:0] dval(int i);
    case (i)
      0: return 64'hFFF0_0000_0000_0000;
      1: return 64'hBFF0_0000_0000_0000;
      2: return 64'h8000_0000_0000_0001;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0000_0000_0000_0000;
      5: return 64'h0000_0000_0000_0001;
      6: return 64'h3FF0_0000_0000_0000;
      7: return 64'h4000_0000_0000_0000;
      8: return 64'h7FF0_0000_0000_0000;
      9: return 64'h7FF8_0000_0000_0000;
      default: return 64'h7FF0_0000_0000_0001;
    endcase
  endfunction

  function automatic int rank(int i);
    if (i <= 3) return i;
    return i - 1;              // both zeros share one rank
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(bit dbl, int i, int j, int f);
    bit nan, snan, lt, eq, gt, un, ill, pred, inv;
    logic [63:0] emask;
    int c;
    @(negedge clk);
    in_valid = 1'b1;
    in_dbl   = dbl;
    in_func  = 6'(f);
    in_a = dbl ? dval(i) : {32'hA5C3_0F1E ^ 32'(i * 7), sval(i)};
    in_b = dbl ? dval(j) : {32'h5A3C_F0E1 ^ 32'(j * 13), sval(j)};
    @(negedge clk);
    in_valid = 1'b0;

    nan  = (i >= 9) || (j >= 9);
    snan = (i == 10) || (j == 10);
    un = nan;
    lt = !nan && rank(i) <  rank(j);
    eq = !nan && rank(i) == rank(j);
    gt = !nan && rank(i) >  rank(j);
    c  = f & 7;
    ill  = 1'b0;
    pred = 1'b0;
    if (f[5]) ill = 1'b1;
    else if (!f[4]) begin
      case (c)
        0: pred = 0;
        1: pred = un;
        2: pred = eq;
        3: pred = un || eq;
        4: pred = lt;
        5: pred = un || lt;
        6: pred = lt || eq;
        default: pred = lt || eq || un;
      endcase
    end else begin
      if (c == 1)      pred = lt || gt || eq;
      else if (c == 2) pred = lt || gt || un;
      else if (c == 3) pred = lt || gt;
      else             ill = 1'b1;
    end
    inv   = !ill && (snan || (f[3] && nan));
    emask = !pred ? 64'h0 : (dbl ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF);
    exp_sticky = exp_sticky | inv;

    chk(out_valid == 1'b1, "R1 valid pulse", 64'(out_valid), 64'd1);
    if (ill)
      chk(out_mask == emask, f[5] ? "R6 mask" : "R5 mask", out_mask, emask);
    else if (f[4])
      chk(out_mask == emask, dbl ? "R4 R7 R2 mask" : "R4 R7 R2 R12 mask",
          out_mask, emask);
    else
      chk(out_mask == emask, dbl ? "R3 R7 R2 mask" : "R3 R7 R2 R12 mask",
          out_mask, emask);
    chk(out_illegal == ill, f[5] ? "R6 illegal" : "R5 illegal",
        64'(out_illegal), 64'(ill));
    chk(out_inv_cause == inv, snan ? "R9 invalid" : "R8 invalid",
        64'(out_inv_cause), 64'(inv));
    chk(out_inv_sticky == exp_sticky, "R10 sticky",
        64'(out_inv_sticky), 64'(exp_sticky));
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dbl = 1'b0;
    in_a = '0; in_b = '0; in_func = '0;
    exp_sticky = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 0,      "R11 valid",  64'(out_valid), 0);
    chk(out_mask == 0,       "R11 mask",   out_mask, 0);
    chk(out_illegal == 0,    "R11 illegal", 64'(out_illegal), 0);
    chk(out_inv_cause == 0,  "R11 cause",  64'(out_inv_cause), 0);
    chk(out_inv_sticky == 0, "R11 sticky", 64'(out_inv_sticky), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R1 idle", 64'(out_valid), 0);

    for (int p = 0; p < 2; p++)
      for (int i = 0; i < NV; i++)
        for (int j = 0; j < NV; j++)
          for (int f = 0; f < 64; f++)
            do_op(p[0], i, j, f);

    @(negedge clk);
    chk(out_valid == 0, "R1 falls", 64'(out_valid), 0);
    chk(out_inv_sticky == exp_sticky, "R10 held idle",
        64'(out_inv_sticky), 64'(exp_sticky));

    rst_n = 1'b0;
    @(negedge clk);
    chk(out_inv_sticky == 0, "R10 R11 sticky cleared by reset",
        64'(out_inv_sticky), 0);
    chk(out_mask == 0, "R11 mask after reset", out_mask, 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule